// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software with a free-running counter that advances on a slow tick derived from the system clock. Software services the watchdog with a single-cycle kick strobe. If the counter reaches the end of its period without a kick, the block first issues a one-cycle non-maskable interrupt pulse. This gives the handler a chance to recover. If a further full period then elapses without a kick, the block raises a system reset request.

The period is chosen from four settings through a select input. With the default parameters and a 32.768 kHz tick, these are 4096, 16384, 65536 and 262144 ticks (125 ms, 500 ms, 2 s, 8 s). A new select value is taken only when the counter restarts, either on a kick or on a period wrap. The reset request stays set until the block's own reset is applied.

Top module: `wdt2_top`

## Requirements
- R1: After reset, `nmi_o` and `sysrst_req_o` are 0, and the period in force is the one of select value `DEF_SEL` (default 0).
- R2: The counter advances only on clock edges where `tick_i` is 1. From the last restart, the `lim`-th tick wraps the counter, where `lim = 2**(BASE_LOG2 + STEP_LOG2*sel)`, with select codes 0..3 running from shortest to longest.
- R3: On the first wrap since reset or since the last kick, `nmi_o` is 1 for exactly the one cycle after the wrapping edge.
- R4: On a wrap while the interrupt has already been raised and no kick has come since, `sysrst_req_o` rises in the cycle after that edge and no NMI pulse is given.
- R5: Once set, `sysrst_req_o` stays at 1 whatever happens on `tick_i` and `kick_i`, until `rst_ni` is asserted. No further NMI pulses are produced in that state.
- R6: A change on `period_sel_i` does not alter the period already running. It takes effect from the next restart (a kick or a wrap).
- R7: A kick clears the counter and the raised-interrupt flag, so the next wrap after a kick gives an NMI pulse and not a reset.
- R8: Cycles with `tick_i` at 0 neither advance the counter nor produce any output.
- R9: A kick has priority over a tick in the same cycle. A wrap that would have happened on that edge is suppressed, and the full period starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Low-speed tick enable, one system cycle wide |
| period_sel_i | input | SEL_W (2) | Period select code, 0 shortest to 3 longest |
| kick_i | input | 1 | Service strobe that restarts the count |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse |
| sysrst_req_o | output | 1 | Sticky system reset request |

## Verification
The tick is driven with random gaps, so the bench counts ticks and not cycles. This separates a counter that advances on every clock from one gated by the tick.

Every select code is run to its wrap, which exposes a wrong period table or a swapped code. The select is also changed in the middle of a period, which shows whether it is latched at restart or used at once.

Sequences without a kick tell the first wrap (NMI) from the second (reset). A kick between wraps shows whether the interrupt flag is really cleared.

A kick placed on the very tick that would wrap, and a long tickless hold one tick short of the wrap, separate the correct priority and gating from designs that leak a pulse.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
   typedef enum logic [1:0] {
      ST_ARMED  = 2'd0,
      ST_WARNED = 2'd1,
      ST_TRIPPED = 2'd2
   } wdt2_stage_e;
endpackage

// File: rtl/wdt2_period_sel.sv
module wdt2_period_sel #(
   parameter int NSEL      = 4,
   parameter int SEL_W     = 2,
   parameter int BASE_LOG2 = 12,
   parameter int STEP_LOG2 = 2,
   parameter int CNT_W     = 18,
   parameter int DEF_SEL   = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] term_o
);
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] term_tab [NSEL];

   // terminal count for each select code: 2**shift - 1
   for (genvar g = 0; g < NSEL; g++) begin : g_term
      localparam int SHIFT = BASE_LOG2 + STEP_LOG2 * g;
      assign term_tab[g] = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << SHIFT) - 1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sel_q <= SEL_W'(DEF_SEL);
      else if (restart_i) sel_q <= sel_i;
   end

   assign term_o = term_tab[sel_q];
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
   parameter int CNT_W = 18
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             kick_i,
   input  logic [CNT_W-1:0] term_i,
   output logic             wrap_o,
   output logic             restart_o
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap_o    = tick_i && !kick_i && (cnt_q == term_i);
   assign restart_o = kick_i || wrap_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (restart_o) cnt_q <= '0;
      else if (tick_i)    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt2_stage_fsm.sv
module wdt2_stage_fsm
   import wdt2_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wrap_i,
   input  logic kick_i,
   output logic nmi_o,
   output logic sysrst_o
);
   wdt2_stage_e stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q  <= ST_ARMED;
         nmi_o    <= 1'b0;
         sysrst_o <= 1'b0;
      end else begin
         nmi_o <= 1'b0;
         if (stage_q != ST_TRIPPED) begin
            if (kick_i) begin
               stage_q <= ST_ARMED;
            end else if (wrap_i) begin
               if (stage_q == ST_ARMED) begin
                  stage_q <= ST_WARNED;
                  nmi_o   <= 1'b1;
               end else begin
                  stage_q  <= ST_TRIPPED;
                  sysrst_o <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top #(
   parameter int NSEL      = 4,
   parameter int BASE_LOG2 = 12,
   parameter int STEP_LOG2 = 2,
   parameter int DEF_SEL   = 0,
   localparam int SEL_W    = $clog2(NSEL),
   localparam int CNT_W    = BASE_LOG2 + STEP_LOG2 * (NSEL - 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] period_sel_i,
   input  logic             kick_i,
   output logic             nmi_o,
   output logic             sysrst_req_o
);
   if (NSEL < 2 || (1 << SEL_W) != NSEL) begin : g_chk_nsel
      $error("wdt2_top: NSEL must be a power of two of at least 2");
   end
   if (BASE_LOG2 < 1 || STEP_LOG2 < 0 || CNT_W > 30) begin : g_chk_width
      $error("wdt2_top: period exponents out of range");
   end
   if (DEF_SEL < 0 || DEF_SEL >= NSEL) begin : g_chk_def
      $error("wdt2_top: DEF_SEL outside select range");
   end

   logic [CNT_W-1:0] term;
   logic             wrap;
   logic             restart;

   wdt2_period_sel #(
      .NSEL(NSEL), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2),
      .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W), .DEF_SEL(DEF_SEL)
   ) u_sel (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
      .sel_i(period_sel_i), .term_o(term)
   );

   wdt2_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
      .term_i(term), .wrap_o(wrap), .restart_o(restart)
   );

   wdt2_stage_fsm u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .kick_i(kick_i),
      .nmi_o(nmi_o), .sysrst_o(sysrst_req_o)
   );
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic tick_i,
   input logic kick_i,
   input logic nmi_o,
   input logic sysrst_req_o
);
   AST_NMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_o |=> !nmi_o); // R3
   AST_NMI_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_o |-> $past(tick_i)); // R8
   AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sysrst_req_o |=> sysrst_req_o); // R5
   AST_NO_NMI_WHEN_TRIPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sysrst_req_o |-> !nmi_o); // R4
   AST_KICK_BLOCKS_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick_i |=> !nmi_o); // R9
   AST_RST_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sysrst_req_o) |-> ($past(tick_i) && !$past(kick_i))); // R4
endmodule

bind wdt2_top wdt2_checker u_wdt2_checker (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
   .nmi_o(nmi_o), .sysrst_req_o(sysrst_req_o)
);

// File: tb/wdt2_top_test.sv
module wdt2_top_test;
   localparam int BASE = 3;
   localparam int STEP = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       kick = 1'b0;
   logic [1:0] sel = 2'd0;
   logic       nmi, sreq;
   int         checks = 0;
   int         errors = 0;
   int         cyc = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   wdt2_top #(.NSEL(4), .BASE_LOG2(BASE), .STEP_LOG2(STEP), .DEF_SEL(0)) uut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .period_sel_i(sel),
      .kick_i(kick), .nmi_o(nmi), .sysrst_req_o(sreq)
   );

   function automatic int lim_of(input int s);
      return 1 << (BASE + STEP * s);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
      end
   endtask

   task automatic step(input bit t, input bit k);
      @(negedge clk);
      tick = t;
      kick = k;
      @(posedge clk);
      #1;
      tick = 1'b0;
      kick = 1'b0;
   endtask

   // run with random tick gaps until the lim-th tick; kind 0 expects NMI, 1 expects reset
   task automatic watch(input int lim, input bit kind, input string req);
      int  n = 0;
      bit  hit = 0;
      for (int i = 0; i < 8 * lim + 16 && !hit; i++) begin
         bit t = ($urandom_range(0, 3) != 0);
         step(t, 1'b0);
         if (t) n++;
         hit = (n == lim);
         if (kind == 1'b0) begin
            check(nmi == hit, req, nmi, hit);
            check(sreq == 1'b0, req, sreq, 0);
         end else begin
            check(sreq == hit, req, sreq, hit);
            check(nmi == 1'b0, req, nmi, 0);
         end
      end
      check(hit, {req, " wrap reached"}, hit, 1);
      step(1'b0, 1'b0);
      check(nmi == 1'b0, "R3 pulse width", nmi, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check(nmi == 1'b0 && sreq == 1'b0, "R1 in reset", {nmi, sreq}, 0);
      rst_n = 1'b1;
      step(1'b0, 1'b0);
      check(nmi == 1'b0 && sreq == 1'b0, "R1 after reset", {nmi, sreq}, 0);

      // R1/R2/R3: default period, then R4 second wrap, R5 sticky
      watch(lim_of(0), 1'b0, "R2 default period NMI");
      watch(lim_of(0), 1'b1, "R4 second wrap reset");
      for (int i = 0; i < 60; i++) begin
         step($urandom_range(0, 1), $urandom_range(0, 1));
         check(sreq == 1'b1, "R5 reset held", sreq, 1);
         check(nmi == 1'b0, "R5 no NMI tripped", nmi, 0);
      end
      do_reset();
      step(1'b0, 1'b0);
      check(sreq == 1'b0 && nmi == 1'b0, "R5 cleared by block reset", sreq, 0);

      // R6: select change mid-period applies at restart only
      sel = 2'd2;
      watch(lim_of(0), 1'b0, "R6 old period kept");
      step(1'b0, 1'b1);
      // R7: kick clears warned flag, next wrap is NMI again
      watch(lim_of(2), 1'b0, "R7 NMI after kick / R6 new period");
      watch(lim_of(2), 1'b1, "R4 reset at select 2");
      do_reset();

      // R2: every select code, random order rounds
      for (int r = 0; r < 8; r++) begin
         int s = (r < 4) ? r : $urandom_range(0, 3);
         sel = 2'(s);
         step(1'b0, 1'b1);
         watch(lim_of(s), 1'b0, $sformatf("R2 period sel %0d", s));
      end

      // R8: hold tick low just before the wrap
      sel = 2'd1;
      step(1'b0, 1'b1);
      for (int i = 0; i < lim_of(1) - 1; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 200; i++) begin
         step(1'b0, 1'b0);
         check(nmi == 1'b0 && sreq == 1'b0, "R8 no tick no event", nmi, 0);
      end
      step(1'b1, 1'b0);
      check(nmi == 1'b1, "R8 wrap on next tick", nmi, 1);
      step(1'b0, 1'b1);

      // R9: kick on the wrapping tick wins
      for (int i = 0; i < lim_of(1) - 1; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      check(nmi == 1'b0, "R9 kick beats wrap", nmi, 0);
      watch(lim_of(1), 1'b0, "R9 full period after kick");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule